// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches the 32 already-synchronized input levels of a GPIO bank and turns them into interrupt events. Each pin is configured on its own: level or edge sensing, which level or edge counts as active, an option to catch both edge directions, and an optional stability filter in front of detection. Captured events are visible in a raw view that ignores the enable and mask bits, and in a status view gated by them. All gated status bits are ORed into a single interrupt request.

Software reaches the configuration through a small word-addressed register port. Every register is split into two words, one for pins 0 to 15 at the base offset and one for pins 16 to 31 at base + 4. In a write, the upper 16 data bits act as per-bit write enables for the lower 16, so single pins can be changed without a read-modify-write. Edge events stay latched until software writes a one to the pin's end-of-interrupt bit.

The per-pin stability filter is a two-state machine. In state ST_STEADY the filtered level is settled; the transition "mismatch" (debounce on and the pin differs from the filtered level) moves to ST_QUALIFY with a count of one. In ST_QUALIFY the transition "glitch" (pin back to the filtered level) returns to ST_STEADY without change, "qualified" (count reached the limit while the pin still differs) loads the new level and returns to ST_STEADY, and "counting" stays in ST_QUALIFY incrementing the count. The transition "bypass" (debounce off) forces ST_STEADY from either state and lets the filtered level follow the pin.

Top module: `gpint_bank`

## Requirements
- R1: Type bit 1 selects edge sensing, 0 selects level sensing; a level-sensed pin shows its raw bit set exactly while the pin is at its active level, with no clock delay when debounce is off.
- R2: Polarity bit 1 selects rising edge or active-high level; polarity bit 0 selects falling edge or active-low level. After reset all pins are level, active-low, so the raw view reads all ones with pins low.
- R3: For an edge-sensed pin with its both-edges bit set, both rising and falling transitions set the latch, whatever the polarity bit; for a level-sensed pin the both-edges bit has no effect.
- R4: Raw status does not depend on enable or mask; status bit = raw AND enable AND NOT mask; the interrupt output is the OR of all status bits.
- R5: A written one (with its write enable) to a pin's end-of-interrupt bit clears that pin's edge latch on the next clock; a new edge in the same clock wins and the latch stays set; on a level-sensed pin the write has no lasting effect while the level stays active.
- R6: Offsets: enable 0x10, mask 0x18, type 0x20, polarity 0x28, both-edges 0x30, debounce 0x38, status 0x50 (read only), raw 0x58 (read only), end-of-interrupt 0x60 (write only, reads 0). Offset +0 holds pins 0 to 15 and +4 pins 16 to 31 in read data bits 15:0; read bits 31:16 are 0.
- R7: On a write, data bit 16+n enables the update of bit n of that word; a bit whose enable is 0 keeps its value. All configuration resets to 0.
- R8: With the debounce bit set, a new pin level reaches detection only after it was sampled unchanged on 4 consecutive clocks; a shorter pulse is ignored. A debounced edge sets the latch one clock after the level is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | 32 | Synchronized pin levels, one bit per pin |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data: bits 31:16 enables, bits 15:0 values |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Assertions watch on every cycle that an edge latch only drops under an end-of-interrupt write, that a clear with no new edge really empties it, that a both-edges pin catches any transition, that the filter only moves its level after a full count, that a write without its enable bit leaves configuration unchanged, and that the interrupt never rises without an enabled, unmasked pin. The exact mode table (each type, polarity and both-edges combination across pins in both halves), the reset read values, the register placement, the set-wins-over-clear collision and the precise debounce latency can only be shown by the bench's scenarios.

// File: rtl/gpint_pkg.sv
`timescale 1ns/1ps
package gpint_pkg;
    localparam int NCFG     = 6;
    localparam int CFG_EN   = 0;
    localparam int CFG_MASK = 1;
    localparam int CFG_TYP  = 2;
    localparam int CFG_POL  = 3;
    localparam int CFG_BOTH = 4;
    localparam int CFG_DEB  = 5;

    localparam int OFS_CFG0 = 'h10;
    localparam int OFS_STAT = 'h50;
    localparam int OFS_RAW  = 'h58;
    localparam int OFS_EOI  = 'h60;

    typedef enum logic {ST_STEADY, ST_QUALIFY} filt_state_e;
endpackage

// File: rtl/gpint_filter.sv
`timescale 1ns/1ps
module gpint_filter
    import gpint_pkg::*;
#(
    parameter int DEB_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic deb_en_i,
    output logic lvl_o
);
    localparam int CW = (DEB_CYCLES > 2) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    filt_state_e   state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          filt_q, filt_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STEADY;
            cnt_q   <= '0;
            filt_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            filt_q  <= filt_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        filt_n  = filt_q;
        if (!deb_en_i) begin
            state_n = ST_STEADY;
            cnt_n   = '0;
            filt_n  = pin_i;
        end else begin
            unique case (state_q)
                ST_STEADY: begin
                    if (pin_i != filt_q) begin
                        state_n = ST_QUALIFY;
                        cnt_n   = CW'(1);
                    end
                end
                ST_QUALIFY: begin
                    if (pin_i == filt_q) begin
                        state_n = ST_STEADY;
                        cnt_n   = '0;
                    end else if (cnt_q == LAST) begin
                        state_n = ST_STEADY;
                        cnt_n   = '0;
                        filt_n  = pin_i;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                default: state_n = ST_STEADY;
            endcase
        end
    end

    assign lvl_o = deb_en_i ? filt_q : pin_i;

    AST_FILT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (deb_en_i && $past(deb_en_i) && filt_q != $past(filt_q))
        |-> ($past(state_q) == ST_QUALIFY && $past(cnt_q) == LAST)); // R8
endmodule

// File: rtl/gpint_detect.sv
`timescale 1ns/1ps
module gpint_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic typ_i,
    input  logic pol_i,
    input  logic both_i,
    input  logic clr_i,
    output logic raw_o
);
    logic prev_q, lat_q;
    logic rise, fall, hit;

    assign rise = lvl_i & ~prev_q;
    assign fall = ~lvl_i & prev_q;
    assign hit  = typ_i & (both_i ? (rise | fall) : (pol_i ? rise : fall));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            lat_q  <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            if (hit)        lat_q <= 1'b1;
            else if (clr_i) lat_q <= 1'b0;
        end
    end

    assign raw_o = typ_i ? lat_q : (lvl_i == pol_i);

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q && !clr_i) |=> lat_q); // R5
    AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && lvl_i == prev_q) |=> !lat_q); // R5
    AST_BOTH_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (typ_i && both_i && lvl_i != prev_q) |=> lat_q); // R3
endmodule

// File: rtl/gpint_regs.sv
`timescale 1ns/1ps
module gpint_regs
    import gpint_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [NPINS-1:0] raw_i,
    input  logic [NPINS-1:0] stat_i,
    output logic [NPINS-1:0] en_o,
    output logic [NPINS-1:0] mask_o,
    output logic [NPINS-1:0] typ_o,
    output logic [NPINS-1:0] pol_o,
    output logic [NPINS-1:0] both_o,
    output logic [NPINS-1:0] deb_o,
    output logic [NPINS-1:0] eoi_o
);
    function automatic logic [AW-4:0] blk(input int ofs);
        logic [AW-1:0] a;
        a = AW'(ofs);
        return a[AW-1:3];
    endfunction

    logic [NPINS-1:0] cfg_q [NCFG];
    logic [NPINS-1:0] wr_mask, wr_val;
    logic             wr_ok;

    assign wr_ok = bus_we && (bus_addr[1:0] == 2'b00);

    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            wr_mask[i] = (bus_addr[2] == (i >= 16)) && bus_wdata[16 + (i % 16)];
            wr_val[i]  = bus_wdata[i % 16];
        end
    end

    for (genvar k = 0; k < NCFG; k++) begin : g_cfg
        logic sel;
        assign sel = wr_ok && (bus_addr[AW-1:3] == blk(OFS_CFG0 + 8 * k));
        always_ff @(posedge clk) begin
            if (!rst_n)   cfg_q[k] <= '0;
            else if (sel) cfg_q[k] <= (cfg_q[k] & ~wr_mask) | (wr_val & wr_mask);
        end
    end

    assign eoi_o  = (wr_ok && bus_addr[AW-1:3] == blk(OFS_EOI)) ? (wr_val & wr_mask) : '0;
    assign en_o   = cfg_q[CFG_EN];
    assign mask_o = cfg_q[CFG_MASK];
    assign typ_o  = cfg_q[CFG_TYP];
    assign pol_o  = cfg_q[CFG_POL];
    assign both_o = cfg_q[CFG_BOTH];
    assign deb_o  = cfg_q[CFG_DEB];

    logic [NPINS-1:0] sel_v;
    logic [31:0]      pad;
    always_comb begin
        sel_v = '0;
        for (int k = 0; k < NCFG; k++)
            if (bus_addr[AW-1:3] == blk(OFS_CFG0 + 8 * k)) sel_v = cfg_q[k];
        if (bus_addr[AW-1:3] == blk(OFS_STAT)) sel_v = stat_i;
        if (bus_addr[AW-1:3] == blk(OFS_RAW))  sel_v = raw_i;
        pad       = 32'(sel_v);
        bus_rdata = {16'h0000, bus_addr[2] ? pad[31:16] : pad[15:0]};
    end

    AST_WE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(OFS_CFG0) && !bus_wdata[16])
        |=> (cfg_q[CFG_EN][0] == $past(cfg_q[CFG_EN][0]))); // R7
endmodule

// File: rtl/gpint_bank.sv
`timescale 1ns/1ps
module gpint_bank
    import gpint_pkg::*;
#(
    parameter int NPINS      = 32,
    parameter int AW         = 8,
    parameter int DEB_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             irq_o
);
    logic [NPINS-1:0] en, mask, typ, pol, both, deb, eoi;
    logic [NPINS-1:0] lvl, raw, stat;

    gpint_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .raw_i(raw), .stat_i(stat),
        .en_o(en), .mask_o(mask), .typ_o(typ), .pol_o(pol), .both_o(both),
        .deb_o(deb), .eoi_o(eoi)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpint_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
            .clk(clk), .rst_n(rst_n), .pin_i(pin_lvl[i]), .deb_en_i(deb[i]),
            .lvl_o(lvl[i])
        );
        gpint_detect u_det (
            .clk(clk), .rst_n(rst_n), .lvl_i(lvl[i]), .typ_i(typ[i]),
            .pol_i(pol[i]), .both_i(both[i]), .clr_i(eoi[i]), .raw_o(raw[i])
        );
    end

    assign stat  = raw & en & ~mask;
    assign irq_o = |stat;

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> |(en & ~mask)); // R4
endmodule

// File: tb/gpint_bank_tb.sv
`timescale 1ns/1ps
module gpint_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_lvl = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_checks = 0;
    int n_fail = 0;

    localparam logic [7:0] A_EN = 8'h10, A_MASK = 8'h18, A_TYP = 8'h20, A_POL = 8'h28,
                           A_BOTH = 8'h30, A_DEB = 8'h38, A_STAT = 8'h50, A_RAW = 8'h58,
                           A_EOI = 8'h60;

    always #2.5 clk = ~clk;

    gpint_bank u_dut (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #0.5 d = bus_rdata;
    endtask

    task automatic set_bit(input logic [7:0] base, input int pin, input logic v);
        wr(base + ((pin >= 16) ? 8'd4 : 8'd0),
           (32'h1 << ((pin % 16) + 16)) | (32'(v) << (pin % 16)));
    endtask

    task automatic rd_bit(input logic [7:0] base, input int pin, output logic b);
        logic [31:0] d;
        rd(base + ((pin >= 16) ? 8'd4 : 8'd0), d);
        b = d[pin % 16];
    endtask

    initial begin
        #1ms;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic b;
        int pins [4] = '{0, 5, 16, 31};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state: config zero, default level active-low, R2 R7 R4
        rd(A_EN, d);        check("R7 reset enable lo", d, 32'h0);
        rd(A_TYP + 8'd4, d); check("R7 reset type hi", d, 32'h0);
        rd(A_RAW, d);       check("R2 reset raw lo active-low", d, 32'h0000_FFFF);
        rd(A_STAT + 8'd4, d); check("R4 reset status hi", d, 32'h0);
        check("R4 reset irq", 32'(irq_o), 32'h0);
        rd(A_EOI, d);       check("R6 eoi reads zero", d, 32'h0);

        // Register placement and write enables: R6 R7
        wr(A_EN + 8'd4, 32'hFFFF_A5C3);
        rd(A_EN + 8'd4, d); check("R6 enable hi word", d, 32'h0000_A5C3);
        rd(A_EN, d);        check("R6 enable lo word untouched", d, 32'h0);
        wr(A_EN + 8'd4, 32'h00F0_0000);
        rd(A_EN + 8'd4, d); check("R7 partial enables", d, 32'h0000_A503);
        wr(A_EN + 8'd4, 32'h0000_0000 | 32'h0000_FFFF);
        rd(A_EN + 8'd4, d); check("R7 no enables no change", d, 32'h0000_A503);
        wr(A_EN + 8'd4, 32'hFFFF_0000);
        rd(A_EN + 8'd4, d); check("R7 cleared", d, 32'h0);

        // Mode sweep: type x polarity x both-edges on pins in each half
        foreach (pins[j]) begin
            for (int m = 0; m < 8; m++) begin
                int p;
                logic t, pl, bo;
                p = pins[j]; t = m[0]; pl = m[1]; bo = m[2];
                set_bit(A_TYP, p, t);
                set_bit(A_POL, p, pl);
                set_bit(A_BOTH, p, bo);
                set_bit(A_EOI, p, 1'b1);
                rd_bit(A_RAW, p, b);
                check("R1 R2 idle low", 32'(b), 32'(t ? 1'b0 : !pl));
                @(negedge clk); pin_lvl[p] = 1'b1;
                rd_bit(A_RAW, p, b);
                check("R1 R2 R3 after rise", 32'(b), 32'(t ? (pl | bo) : pl));
                set_bit(A_EOI, p, 1'b1);
                rd_bit(A_RAW, p, b);
                check("R5 after eoi high", 32'(b), 32'(t ? 1'b0 : pl));
                @(negedge clk); pin_lvl[p] = 1'b0;
                rd_bit(A_RAW, p, b);
                check("R1 R2 R3 after fall", 32'(b), 32'(t ? (!pl | bo) : !pl));
                set_bit(A_EOI, p, 1'b1);
                rd_bit(A_RAW, p, b);
                check("R5 after eoi low", 32'(b), 32'(t ? 1'b0 : !pl));
            end
        end

        // Enable, mask and combined request on pin 7 (rising edge): R4
        set_bit(A_TYP, 7, 1'b1);
        set_bit(A_POL, 7, 1'b1);
        set_bit(A_EN, 7, 1'b1);
        set_bit(A_EOI, 7, 1'b1);
        @(negedge clk); pin_lvl[7] = 1'b1;
        rd(A_STAT, d); check("R4 status enabled", d, 32'h0000_0080);
        check("R4 irq enabled", 32'(irq_o), 32'h1);
        set_bit(A_MASK, 7, 1'b1);
        rd(A_STAT, d); check("R4 status masked", d, 32'h0);
        check("R4 irq masked", 32'(irq_o), 32'h0);
        rd_bit(A_RAW, 7, b); check("R4 raw ignores mask", 32'(b), 32'h1);
        set_bit(A_MASK, 7, 1'b0);
        set_bit(A_EN, 7, 1'b0);
        check("R4 irq disabled", 32'(irq_o), 32'h0);
        rd_bit(A_RAW, 7, b); check("R4 raw ignores enable", 32'(b), 32'h1);

        // Set wins over same-cycle clear: R5
        @(negedge clk); pin_lvl[7] = 1'b0;
        set_bit(A_EOI, 7, 1'b1);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = A_EOI; bus_wdata = 32'h0080_0080; pin_lvl[7] = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        rd_bit(A_RAW, 7, b); check("R5 edge wins over clear", 32'(b), 32'h1);

        // Debounce on pin 3 (rising edge): R8
        set_bit(A_TYP, 3, 1'b1);
        set_bit(A_POL, 3, 1'b1);
        set_bit(A_DEB, 3, 1'b1);
        set_bit(A_EOI, 3, 1'b1);
        @(negedge clk); pin_lvl[3] = 1'b1;
        repeat (2) @(negedge clk);
        rd_bit(A_RAW, 3, b); check("R8 short pulse pending", 32'(b), 32'h0);
        pin_lvl[3] = 1'b0;
        rd_bit(A_RAW, 3, b); check("R8 short pulse ignored", 32'(b), 32'h0);
        rd_bit(A_RAW, 3, b); check("R8 short pulse still ignored", 32'(b), 32'h0);
        @(negedge clk); pin_lvl[3] = 1'b1;
        repeat (3) @(negedge clk);
        rd_bit(A_RAW, 3, b); check("R8 accepted not yet latched", 32'(b), 32'h0);
        rd_bit(A_RAW, 3, b); check("R8 latched after 4 samples", 32'(b), 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule